// File: doc/BRIEF.md
# Multichannel Ramped Logarithmic Attenuator

This block scales a time-multiplexed stream of 24-bit signed audio samples. Each of its eight channels has an 8-bit attenuation setting. A setting of 0 gives unity gain. Each further step removes 0.375 dB, so the usable range runs to roughly 95 dB below full scale, and the top settings silence the channel completely. Samples arrive one per strobe, each tagged with a channel number. The scaled result leaves one clock later with the same tag.

The block does not apply a new setting at once. It keeps a working code for every channel, and that code moves one step toward the requested setting each time a sample of that channel passes through. A soft-mute bit forces the requested setting to full silence, so muting and unmuting both fade instead of clicking. On reset every channel starts silent, and the first settings written fade the channels in. The gain for a code is a 16-entry mantissa covering one 6 dB span, followed by one right shift for each whole group of 16 codes.

Top module: `vol_ramp`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0 and out_data is 0. Every channel's working code starts at 255, so the first samples after reset come out as zero.
- R2: out_valid is in_valid delayed by one clock. When out_valid is 1, out_chan equals the in_chan that was presented with the sample.
- R3: Each sample is scaled with its channel's working code as it stood before that sample. The same sample then moves the code by exactly one toward the requested code, or leaves it unchanged if the two are already equal.
- R4: For a working code k below 253, the output is (x·M[k mod 16] + 2^(s−1)) >> s, with an arithmetic shift, where s = 16 + floor(k/16). M is, in order of index 0 to 15: 65536, 62767, 60115, 57574, 55142, 52812, 50580, 48443, 46396, 44435, 42558, 40760, 39037, 37388, 35808, 34295. The result is clamped to the 24-bit signed range.
- R5: A working code of 253, 254 or 255 produces an output of exactly 0, whatever the input sample.
- R6: Bit c of mute makes the requested code of channel c equal to 255 while it is set. When the bit is cleared, the channel ramps back to its value in target_codes (bits 8c+7 down to 8c).
- R7: A sample on one channel leaves the working codes of all other channels unchanged.
- R8: If the requested code changes while a ramp is in progress, the working code turns toward the new value from its current position, one step per sample.
- R9: A clock cycle without in_valid changes no working code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is presented this cycle |
| in_chan | input | 3 | Channel number of the presented sample |
| in_data | input | 24 | Signed input sample |
| target_codes | input | 64 | Requested attenuation code per channel, 8 bits each, channel 0 in the lowest byte |
| mute | input | 8 | Soft-mute request, one bit per channel |
| out_valid | output | 1 | A scaled sample is on out_data |
| out_chan | output | 3 | Channel number of the scaled sample |
| out_data | output | 24 | Signed scaled sample |

## Verification
The assertions assume that reset is applied before the first sample. They also assume that whenever in_valid is high, in_chan names an existing channel; with the default of eight channels, every 3-bit value qualifies. Settings and mute bits are free to change in any cycle, and the stimulus does exactly that. It rewrites targets in the middle of ramps and toggles mute during both fades. It also sends samples of full-scale positive and negative value, so that rounding is exercised at its extremes.

// File: rtl/vol_ramp.sv
module vol_ramp #(
  parameter int CHANNELS  = 8,
  parameter int DW        = 24,
  parameter int CW        = 8,
  parameter int MUTE_CODE = 253
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [$clog2(CHANNELS)-1:0] in_chan,
  input  logic signed [DW-1:0]     in_data,
  input  logic [CHANNELS*CW-1:0]   target_codes,
  input  logic [CHANNELS-1:0]      mute,
  output logic                     out_valid,
  output logic [$clog2(CHANNELS)-1:0] out_chan,
  output logic signed [DW-1:0]     out_data
);
  localparam int MW = 17;
  localparam int PW = DW + MW + 1;
  localparam logic signed [PW-1:0] ONE = 1;
  localparam logic signed [PW-1:0] HI  = (ONE <<< (DW-1)) - ONE;
  localparam logic signed [PW-1:0] LO  = -HI - ONE;

  logic [CW-1:0] cur [CHANNELS];
  logic [CW-1:0] eff [CHANNELS];
  logic [CW-1:0] applied;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_eff
    assign eff[g] = mute[g] ? {CW{1'b1}} : target_codes[g*CW +: CW];
  end

  function automatic logic [MW-1:0] mant(input logic [3:0] m);
    case (m)
      4'd0:  mant = 17'd65536;
      4'd1:  mant = 17'd62767;
      4'd2:  mant = 17'd60115;
      4'd3:  mant = 17'd57574;
      4'd4:  mant = 17'd55142;
      4'd5:  mant = 17'd52812;
      4'd6:  mant = 17'd50580;
      4'd7:  mant = 17'd48443;
      4'd8:  mant = 17'd46396;
      4'd9:  mant = 17'd44435;
      4'd10: mant = 17'd42558;
      4'd11: mant = 17'd40760;
      4'd12: mant = 17'd39037;
      4'd13: mant = 17'd37388;
      4'd14: mant = 17'd35808;
      default: mant = 17'd34295;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                 input logic [CW-1:0] code);
    logic signed [PW-1:0] p;
    int sh;
    if (code >= CW'(MUTE_CODE)) return '0;
    sh = 16 + int'(code[CW-1:4]);
    p  = x * $signed({1'b0, mant(code[3:0])});
    p  = (p + (ONE <<< (sh - 1))) >>> sh;
    if (p > HI) p = HI;
    if (p < LO) p = LO;
    return p[DW-1:0];
  endfunction

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic [CW-1:0] t);
    if (c < t)      return c + 1'b1;
    else if (c > t) return c - 1'b1;
    else            return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
      applied   <= '1;
      for (int i = 0; i < CHANNELS; i++) cur[i] <= '1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan     <= in_chan;
        out_data     <= scale(in_data, cur[in_chan]);
        applied      <= cur[in_chan];
        cur[in_chan] <= step(cur[in_chan], eff[in_chan]);
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && applied >= CW'(MUTE_CODE)) |-> out_data == '0); // R5

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cur[g] == $past(cur[g]) || cur[g] == $past(cur[g]) + 1'b1
                || cur[g] + 1'b1 == $past(cur[g]))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(cur[g])); // R9
    AST_OTHER_CHANNELS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_chan != g) |=> $stable(cur[g])); // R7
    AST_MUTE_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mute[g] && cur[g] == {CW{1'b1}}) |=> cur[g] == {CW{1'b1}}); // R6
  end
endmodule

// File: tb/vol_ramp_test.sv
module vol_ramp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_chan = '0;
  logic signed [23:0] in_data = '0;
  logic [63:0] tgt = '0;
  logic [7:0] mute = '0;
  logic out_valid;
  logic [2:0] out_chan;
  logic signed [23:0] out_data;

  int compared = 0;
  int mismatched = 0;
  string req = "R1";
  int mcur [8];
  int mtab [16] = '{65536, 62767, 60115, 57574, 55142, 52812, 50580, 48443,
                    46396, 44435, 42558, 40760, 39037, 37388, 35808, 34295};
  bit exp_valid = 0;
  int exp_chan = 0;
  longint exp_data = 0;

  vol_ramp uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
                .in_data(in_data), .target_codes(tgt), .mute(mute),
                .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data));

  always #5 clk = ~clk;

  function automatic longint ref_scale(longint x, int code);
    longint r;
    int sh;
    if (code >= 253) return 0;
    sh = 16 + code / 16;
    r = (x * mtab[code % 16] + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  task automatic check(string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    int c, t;
    @(posedge clk);
    if (!rst_n) begin
      exp_valid = 0;
      exp_data = 0;
      for (int i = 0; i < 8; i++) mcur[i] = 255;
    end else begin
      exp_valid = in_valid;
      if (in_valid) begin
        c = int'(in_chan);
        t = mute[c] ? 255 : int'(tgt[c*8 +: 8]);
        exp_chan = c;
        exp_data = ref_scale(longint'(in_data), mcur[c]);
        if (mcur[c] < t) mcur[c]++;
        else if (mcur[c] > t) mcur[c]--;
      end
    end
    @(negedge clk);
    check("out_valid", longint'(out_valid), longint'(exp_valid));
    if (!rst_n || exp_valid) check("out_data", longint'(out_data), exp_data);
    if (exp_valid) check("out_chan", longint'(out_chan), longint'(exp_chan));
  endtask

  task automatic send(int ch, int d);
    in_valid = 1'b1;
    in_chan = 3'(ch);
    in_data = 24'(d);
    tick();
    in_valid = 1'b0;
  endtask

  function automatic int pat(int i);
    case (i % 5)
      0: return 8388607;
      1: return -8388608;
      2: return 1234567;
      3: return -5;
      default: return -3000001;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) mcur[i] = 255;
    req = "R1";
    tick(); tick(); tick();
    rst_n = 1'b1;
    send(0, 8388607);
    send(0, -8388608);

    req = "R4";
    for (int i = 0; i < 300; i++) send(0, pat(i));

    req = "R9";
    tick(); tick(); tick(); tick();
    tgt[7:0] = 8'd100;
    for (int i = 0; i < 6; i++) tick();
    tgt[7:0] = 8'd0;
    send(0, 8388607);
    send(0, -1);

    req = "R7";
    tgt[15:8] = 8'd40;
    for (int i = 0; i < 20; i++) send(1, pat(i));
    send(0, 4095);
    for (int i = 0; i < 10; i++) send(3, 8388607);
    send(1, -77777);

    req = "R6";
    mute[0] = 1'b1;
    for (int i = 0; i < 270; i++) send(0, pat(i));
    mute[0] = 1'b0;
    tgt[7:0] = 8'd20;
    for (int i = 0; i < 260; i++) send(0, pat(i + 1));

    req = "R8";
    tgt[23:16] = 8'd100;
    for (int i = 0; i < 50; i++) send(2, pat(i));
    tgt[23:16] = 8'd250;
    for (int i = 0; i < 60; i++) send(2, pat(i));

    req = "R5";
    tgt[39:32] = 8'd253;
    for (int i = 0; i < 10; i++) send(4, 8388607);
    tgt[39:32] = 8'd240;
    for (int i = 0; i < 20; i++) send(4, -8388608);

    req = "R3";
    tgt[47:40] = 8'd128;
    for (int i = 0; i < 140; i++) send(5, 7000000 - i * 1000);

    req = "R2";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 40) == 0) tgt[$urandom_range(0, 7)*8 +: 8] = 8'($urandom);
      if ($urandom_range(0, 60) == 0) mute = mute ^ (8'd1 << $urandom_range(0, 7));
      in_valid = 1'($urandom_range(0, 3) != 0);
      in_chan = 3'($urandom);
      in_data = 24'($urandom);
      tick();
    end
    in_valid = 1'b0;
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule